// File: doc/BRIEF.md
# Dual-Clock ECG Sample Buffer with Host Wake Interrupt

This block sits between a slow acquisition domain and a faster host domain. Once per sample period the acquisition side offers a 16-bit word, either a digitised ECG sample or a heart-rate word, and the block stores it. The host side pops stored words in arrival order through a simple pop interface. Each side keeps a binary position counter. Each counter is turned into Gray code and passed through a two-flop synchronizer into the other domain. Each domain then works out its own flags from its own counter and the synchronized copy of the other one.

Four status levels are provided. The write domain produces full and a programmable nearly-full. The read domain produces empty and a programmable nearly-empty. A small state machine in the read domain lets the host sleep while the buffer fills. When the read side sees the buffer full, the machine raises `host_irq` and holds it until the host takes its first word. It then stays in a draining state until the buffer is empty, and after that it waits for the next full buffer.

Both edges follow valid/ready rules. On the write side `wr_ready` is low only while the buffer is full. The acquisition source cannot stall, so a word offered while `wr_ready` is low is dropped and recorded. On the read side `rd_valid` shows that `rd_data` holds the oldest word, and a word is consumed on a read-clock edge where both `rd_valid` and `rd_ready` are high. Raising `rd_ready` while `rd_valid` is low consumes nothing and is recorded.

Top module: `ecg_sample_fifo`

## Requirements
- R1: After reset, `empty`, `nearly_empty` and `wr_ready` are 1. `full`, `nearly_full`, `rd_valid`, `host_irq`, `overflow_err` and `underflow_err` are 0.
- R2: Words come out on `rd_data` in the order they were accepted, with unchanged values. While `rd_valid` is 1, `rd_data` holds the oldest stored word.
- R3: With DEPTH words stored (default 512), `full` is 1 and `wr_ready` is 0. A word offered while `full` is 1 is not stored and never appears on `rd_data`. It sets `overflow_err`, which stays 1 until write reset.
- R4: A pop request while `empty` is 1 changes no stored state: `empty` stays 1 and the next written word is the next word read. It sets `underflow_err`, which stays 1 until read reset.
- R5: `nearly_full` is 1 exactly when the write-side occupancy is at least DEPTH minus AF_LEVEL (default: 496 or more words).
- R6: `nearly_empty` is 1 exactly when the read-side occupancy is at most AE_LEVEL (default: 16 or fewer words).
- R7: `host_irq` rises once the read side sees DEPTH words stored. It then holds until the first accepted pop and is 0 from the read-clock edge of that pop onward.
- R8: After the interrupt, the block does not raise `host_irq` again until the buffer has drained to empty and then filled to DEPTH once more. A partial refill below DEPTH leaves it at 0.
- R9: A word accepted into an empty buffer clears `empty` no later than the third read-clock edge after the write edge. A pop from a full buffer clears `full` no later than the third write-clock edge after the pop edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Acquisition (write) clock |
| wrst_n | input | 1 | Write-domain reset, active low, asynchronous |
| wr_valid | input | 1 | A word is offered this cycle |
| wr_data | input | 16 | Offered word |
| wr_ready | output | 1 | Buffer can accept a word (not full) |
| full | output | 1 | DEPTH words stored, write-domain view |
| nearly_full | output | 1 | Free space at or below AF_LEVEL |
| overflow_err | output | 1 | Sticky: a word was offered while full |
| rclk | input | 1 | Host (read) clock |
| rrst_n | input | 1 | Read-domain reset, active low, asynchronous |
| rd_ready | input | 1 | Host requests a pop |
| rd_valid | output | 1 | `rd_data` holds a stored word |
| rd_data | output | 16 | Oldest stored word |
| empty | output | 1 | No word stored, read-domain view |
| nearly_empty | output | 1 | Occupancy at or below AE_LEVEL |
| underflow_err | output | 1 | Sticky: pop requested while empty |
| host_irq | output | 1 | Buffer full, host should start reading |

## Verification
Results that stay in one domain take effect at the edge that accepts the stimulus. Full, nearly-full, overflow, empty, nearly-empty, underflow and the interrupt drop are therefore checked 1 ns after that edge. Effects that cross domains (empty clearing, full clearing, the interrupt rising) pass through a Gray register and two synchronizer flops, so they are due by the third edge of the far clock. The bench either samples exactly after that third edge, or waits a settle interval of several far-clock cycles before it compares. Popped words are compared by a monitor at the falling read-clock edge before the accepting edge, against a queue filled only with words the bench's own occupancy count says were accepted.

// File: rtl/ecg_fifo_pkg.sv
package ecg_fifo_pkg;
  // Interrupt-and-drain controller states, read domain
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_IRQ   = 2'd1,
    ST_DRAIN = 2'd2
  } drain_state_e;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DW = 16,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl #(
  parameter int DEPTH    = 512,
  parameter int AF_LEVEL = 16,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_en,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q,
  output logic          full,
  output logic          nearly_full,
  output logic          overflow_err
);
  logic [PW-1:0] rbin_s, bin_nx, occ;

  // Gray to binary for the synchronized read position
  always_comb begin
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign occ         = bin_q - rbin_s;
  assign full        = (occ == PW'(DEPTH));
  assign nearly_full = (occ >= PW'(DEPTH - AF_LEVEL));
  assign wr_en       = wr_valid && !full;
  assign bin_nx      = bin_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q        <= '0;
      gray_q       <= '0;
      overflow_err <= 1'b0;
    end else begin
      if (wr_en) begin
        bin_q  <= bin_nx;
        gray_q <= bin_nx ^ (bin_nx >> 1);
      end
      if (wr_valid && full) overflow_err <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import ecg_fifo_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int AE_LEVEL = 16,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic [PW-1:0] wgray_s,
  output logic          rd_en,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q,
  output logic          empty,
  output logic          nearly_empty,
  output logic          underflow_err,
  output logic          host_irq
);
  logic [PW-1:0] wbin_s, bin_nx, occ;
  drain_state_e  state_q, state_d;

  always_comb begin
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW-2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign occ          = wbin_s - bin_q;
  assign empty        = (occ == '0);
  assign nearly_empty = (occ <= PW'(AE_LEVEL));
  assign rd_en        = rd_ready && !empty;
  assign bin_nx       = bin_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q         <= '0;
      gray_q        <= '0;
      underflow_err <= 1'b0;
    end else begin
      if (rd_en) begin
        bin_q  <= bin_nx;
        gray_q <= bin_nx ^ (bin_nx >> 1);
      end
      if (rd_ready && empty) underflow_err <= 1'b1;
    end
  end

  // Interrupt-and-drain sequencing
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL:  if (occ == PW'(DEPTH)) state_d = ST_IRQ;
      ST_IRQ:   if (rd_en)             state_d = ST_DRAIN;
      ST_DRAIN: if (empty)             state_d = ST_FILL;
      default:                         state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FILL;
    else        state_q <= state_d;
  end

  assign host_irq = (state_q == ST_IRQ);
endmodule

// File: rtl/ecg_sample_fifo.sv
module ecg_sample_fifo #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 512,
  parameter int AF_LEVEL    = 16,
  parameter int AE_LEVEL    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              full,
  output logic              nearly_full,
  output logic              overflow_err,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              nearly_empty,
  output logic              underflow_err,
  output logic              host_irq
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic             wr_en, rd_en;
  logic [PTR_W-1:0] w_bin, w_gray, r_bin, r_gray, wgray_s, rgray_s;

  fifo_wr_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_valid(wr_valid), .rgray_s(rgray_s),
    .wr_en(wr_en), .bin_q(w_bin), .gray_q(w_gray), .full(full),
    .nearly_full(nearly_full), .overflow_err(overflow_err)
  );

  fifo_rd_ctrl #(.DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_ready(rd_ready), .wgray_s(wgray_s),
    .rd_en(rd_en), .bin_q(r_bin), .gray_q(r_gray), .empty(empty),
    .nearly_empty(nearly_empty), .underflow_err(underflow_err),
    .host_irq(host_irq)
  );

  fifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(w_gray), .q(wgray_s)
  );

  fifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(r_gray), .q(rgray_s)
  );

  fifo_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_en), .waddr(w_bin[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(r_bin[ADDR_W-1:0]), .rdata(rd_data)
  );

  assign wr_ready = ~full;
  assign rd_valid = ~empty;
endmodule

// File: rtl/ecg_fifo_chk.sv
module ecg_fifo_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          wr_valid,
  input logic          full,
  input logic          nearly_full,
  input logic          overflow_err,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic          empty,
  input logic          nearly_empty,
  input logic          underflow_err,
  input logic          host_irq,
  input logic [PW-1:0] w_bin,
  input logic [PW-1:0] r_bin
);
  // R3: offered word while full leaves the write position untouched
  p_full_holds_wptr_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wr_valid) |=> $stable(w_bin));

  // R3: overflow flag is sticky
  p_ovf_sticky_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow_err |=> overflow_err);

  // R4: pop request on empty leaves the read position untouched
  p_empty_holds_rptr_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && rd_ready) |=> $stable(r_bin));

  // R4: underflow flag is sticky
  p_unf_sticky_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    underflow_err |=> underflow_err);

  // R5: full implies nearly full
  p_full_in_nf_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> nearly_full);

  // R6: empty implies nearly empty
  p_empty_in_ne_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> nearly_empty);

  // R7: interrupt drops after the first accepted pop
  p_irq_drop_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (host_irq && rd_valid && rd_ready) |=> !host_irq);

  // R7: interrupt holds while no pop is accepted
  p_irq_hold_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (host_irq && !(rd_valid && rd_ready)) |=> host_irq);

  // R8: interrupt only while words are stored
  p_irq_not_empty_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    host_irq |-> !empty);
endmodule

bind ecg_sample_fifo ecg_fifo_chk #(.PW(PTR_W)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .wr_valid(wr_valid), .full(full), .nearly_full(nearly_full),
  .overflow_err(overflow_err), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .empty(empty), .nearly_empty(nearly_empty), .underflow_err(underflow_err),
  .host_irq(host_irq), .w_bin(w_bin), .r_bin(r_bin)
);

// File: tb/sim_ecg_sample_fifo.sv
`timescale 1ns/1ps
module sim_ecg_sample_fifo;
  localparam int DEPTH = 512;
  localparam int AFL   = 16;
  localparam int AEL   = 16;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready, full, nearly_full, overflow_err;
  logic        rd_valid, empty, nearly_empty, underflow_err, host_irq;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #2 rclk = ~rclk;                 // 250 MHz host clock
  initial begin #1; forever #5 wclk = ~wclk; end

  ecg_sample_fifo u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .full(full), .nearly_full(nearly_full),
    .overflow_err(overflow_err), .rclk(rclk), .rrst_n(rrst_n),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .empty(empty), .nearly_empty(nearly_empty),
    .underflow_err(underflow_err), .host_irq(host_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: compares each popped word against the scoreboard (R2)
  always @(negedge rclk) begin
    if (rd_ready && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected word", int'(rd_data), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R2 order/value", int'(rd_data), int'(e));
      end
    end
  end

  // Watchdog
  always @(posedge rclk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 0);
      summary();
    end
  end

  // Driver: one write; the scoreboard only learns words the model says fit
  task automatic wr_push(input logic [15:0] d);
    @(posedge wclk); #1;
    wr_valid = 1'b1; wr_data = d;
    @(posedge wclk); #1;
    wr_valid = 1'b0;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
  endtask

  task automatic rd_pop();
    @(posedge rclk); #1; rd_ready = 1'b1;
    @(posedge rclk); #1; rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    #1;
  endtask

  task automatic drain_all(input bit check_levels);
    while (exp_q.size() > 0) begin
      rd_pop();
      if (check_levels) begin
        chk(nearly_empty == (exp_q.size() <= AEL), "R6 nearly_empty",
            int'(nearly_empty), int'(exp_q.size() <= AEL));
        chk(empty == (exp_q.size() == 0), "R6 empty level",
            int'(empty), int'(exp_q.size() == 0));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge rclk);
    #1; wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (2) @(posedge rclk); #1;

    // R1 reset state
    chk(empty && nearly_empty && wr_ready, "R1 set flags",
        {empty, nearly_empty, wr_ready}, 3'b111);
    chk(!full && !nearly_full && !rd_valid && !host_irq, "R1 clear flags",
        {full, nearly_full, rd_valid, host_irq}, 0);
    chk(!overflow_err && !underflow_err, "R1 errors",
        {overflow_err, underflow_err}, 0);

    // R9: empty clears by the third read edge after the write edge
    @(posedge wclk); #1; wr_valid = 1'b1; wr_data = 16'h1234;
    @(posedge wclk); wr_valid <= 1'b0;
    exp_q.push_back(16'h1234);
    repeat (3) @(posedge rclk); #1;
    chk(!empty && rd_valid, "R9 empty clears", int'(empty), 0);

    // R2: short burst with varied patterns
    wr_push(16'h0000); wr_push(16'hFFFF); wr_push(16'hA5A5); wr_push(16'h5A5A);
    settle();
    chk(!host_irq, "R8 no irq on partial fill", int'(host_irq), 0);
    drain_all(0);
    settle();
    chk(empty && !rd_valid, "R2 empty after burst", int'(empty), 1);

    // R4: pop while empty
    chk(!underflow_err, "R4 no underflow yet", int'(underflow_err), 0);
    rd_pop();
    chk(underflow_err, "R4 underflow set", int'(underflow_err), 1);
    chk(empty && !rd_valid, "R4 still empty", int'(empty), 1);
    wr_push(16'hBEEF);
    settle();
    drain_all(0);
    settle();

    // R3/R5: fill to DEPTH
    for (int i = 1; i <= DEPTH; i++) begin
      wr_push(16'((i * 37) ^ 16'hC3A5));
      if (i == DEPTH - AFL - 1)
        chk(!nearly_full, "R5 below level", int'(nearly_full), 0);
      if (i == DEPTH - AFL)
        chk(nearly_full, "R5 at level", int'(nearly_full), 1);
      if (i == DEPTH - 1) begin
        chk(!full && wr_ready, "R3 one short of full", int'(full), 0);
        repeat (6) @(posedge rclk); #1;
        chk(!host_irq, "R7 no early irq", int'(host_irq), 0);
      end
    end
    chk(full && !wr_ready, "R3 full", {full, wr_ready}, 2'b10);

    // R3: overflow write dropped
    chk(!overflow_err, "R3 no overflow yet", int'(overflow_err), 0);
    wr_push(16'hDEAD);
    chk(overflow_err && full, "R3 overflow set", {overflow_err, full}, 2'b11);

    // R7: interrupt rises and holds
    settle();
    chk(host_irq, "R7 irq raised", int'(host_irq), 1);
    repeat (20) @(posedge rclk); #1;
    chk(host_irq, "R7 irq held", int'(host_irq), 1);
    rd_pop();
    chk(!host_irq, "R7 irq drops on first pop", int'(host_irq), 0);

    // R9: full clears by the third write edge after the pop edge
    repeat (3) @(posedge wclk); #1;
    chk(!full && wr_ready, "R9 full clears", int'(full), 0);

    // R6: drain with level checks
    drain_all(1);
    settle();
    chk(!host_irq && empty, "R8 idle after drain", {host_irq, empty}, 2'b01);

    // R8: second fill raises the interrupt again
    for (int i = 0; i < DEPTH; i++) wr_push(16'(i * 1021 + 7));
    settle();
    chk(host_irq, "R8 irq again", int'(host_irq), 1);
    drain_all(0);
    settle();
    chk(exp_q.size() == 0 && empty, "R3 no dropped word read", exp_q.size(), 0);
    chk(overflow_err && underflow_err, "R3 R4 sticky errors",
        {overflow_err, underflow_err}, 2'b11);

    done = 1;
    summary();
  end
endmodule